// File: doc/BRIEF.md
# Fuse Key Fetch Sequencer

The sequencer builds a key of several 32-bit words out of a window of fuse rows. A single start pulse captures a first row, a last row and the number of words wanted. The block then walks the window upward one row at a time through a request/acknowledge read port. A row that comes back flagged with an ECC error or with any fail bit set is passed over. Every other row gives its data word to the key stream, tagged with the word's position in the key.

While it collects words, the block keeps two summaries: the bitwise OR and the bitwise AND of every accepted word. When it finishes, it gives a single pass/fail verdict. A key that is blank (all zeros) or fully set (all ones) fails. A fetch whose row pointer ran past the last row also fails. Because the pointer moves after every read, this includes the case where the final word arrived from the last row itself. A request for zero words, or a first row above the last row, is refused at once without touching the port.

Top module: `fuse_key_seq`

## Requirements
- R1: Reads start at the captured first row and go up by exactly one row per acknowledged read. Only one read is ever outstanding, and `rd_row_o` holds steady while a request waits for its acknowledge.
- R2: An acknowledged row with `rd_ecc_err_i` high or any bit of `rd_fail_i` high yields no key word, but the row pointer still advances.
- R3: An acknowledged good row drives `key_valid_o` high for one cycle, in the cycle after the acknowledge. `key_word_o` then carries that row's `rd_data_i`, and `key_idx_o` carries the count of words accepted before it, starting at 0.
- R4: The fetch ends once the requested number of words has been accepted, or once the row pointer has passed the last row, whichever comes first. No further reads are issued after that.
- R5: The verdict is fail when the AND of all accepted words is all ones. This includes the case where no word was accepted.
- R6: The verdict is fail when the OR of all accepted words is zero.
- R7: The verdict is fail when the row pointer ended above the last row. This holds even if the final word was taken from the last row.
- R8: A start with a word count of 0, or with a first row greater than the last row, issues no read. It produces `done_o` with `pass_o` low in the cycle after the start.
- R9: `busy_o` is low after reset and in idle. It is high from the cycle after an accepted start through the `done_o` cycle. `done_o` is a one-cycle pulse, and `start_i` is ignored while `busy_o` is high.
- R10: In every other case the verdict is pass. `pass_o` is high only together with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a fetch (taken only when idle) |
| start_row_i | input | ROW_W | First row of the window |
| end_row_i | input | ROW_W | Last row of the window |
| nwords_i | input | CNT_W | Number of key words wanted |
| rd_req_o | output | 1 | Row read request |
| rd_row_o | output | ROW_W | Row being read |
| rd_ack_i | input | 1 | Read response valid this cycle |
| rd_data_i | input | WORD_W | Row data word |
| rd_ecc_err_i | input | 1 | Row ECC error flag |
| rd_fail_i | input | FAIL_W | Row fail bits |
| key_valid_o | output | 1 | Key word strobe |
| key_word_o | output | WORD_W | Key word |
| key_idx_o | output | CNT_W | Position of the word in the key |
| busy_o | output | 1 | Fetch in progress |
| done_o | output | 1 | One-cycle end-of-fetch pulse |
| pass_o | output | 1 | Verdict, valid with done_o |

## Verification
The assertions check the following on every cycle:
- The row sequence advances by one per acknowledge and holds while stalled.
- A flagged row never produces a key strobe, and a good row's data appears on the next cycle.
- `done_o` is a pulse inside the busy window, and refused starts end at once.
- A pass never follows a blank or full key, nor a fetch whose last read was at the last row.

Only the bench's sweeps can show the rest. It runs every first/last row pair and word count over several row-content patterns and read latencies. This shows that the complete word list, the word indices, the set of rows visited and the exact verdict match an arithmetic model. It also shows that a start held high into the busy period leaves the result unchanged.

// File: rtl/fks_pkg.sv
package fks_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_FIN  = 2'd2
  } fks_state_e;
endpackage

// File: rtl/fks_row_filter.sv
module fks_row_filter #(
  parameter int FAIL_W = 9
) (
  input  logic              ecc_err_i,
  input  logic [FAIL_W-1:0] fail_i,
  output logic              good_o
);
  assign good_o = !ecc_err_i && (fail_i == '0);
endmodule

// File: rtl/fks_accum.sv
module fks_accum #(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              upd_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ok_o
);
  logic [WORD_W-1:0] or_q, and_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      or_q  <= '0;
      and_q <= '1;
    end else if (clr_i) begin
      or_q  <= '0;
      and_q <= '1;
    end else if (upd_i) begin
      or_q  <= or_q | word_i;
      and_q <= and_q & word_i;
    end
  end

  // blank or fully-set key is rejected
  assign ok_o = (or_q != '0) && (and_q != '1);
endmodule

// File: rtl/fks_ctrl.sv
module fks_ctrl
  import fks_pkg::*;
#(
  parameter int ROW_W  = 10,
  parameter int WORD_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ROW_W-1:0]  start_row_i,
  input  logic [ROW_W-1:0]  end_row_i,
  input  logic [CNT_W-1:0]  nwords_i,
  input  logic              rd_ack_i,
  input  logic              row_good_i,
  input  logic [WORD_W-1:0] rd_data_i,
  input  logic              acc_ok_i,
  output logic              launch_o,
  output logic              accept_o,
  output logic              rd_req_o,
  output logic [ROW_W-1:0]  rd_row_o,
  output logic              key_valid_o,
  output logic [WORD_W-1:0] key_word_o,
  output logic [CNT_W-1:0]  key_idx_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o
);
  localparam int PTR_W = ROW_W + 1;

  fks_state_e        state_q;
  logic [PTR_W-1:0]  row_q;
  logic [ROW_W-1:0]  end_q;
  logic [CNT_W-1:0]  rem_q, idx_q;
  logic              bad_q;
  logic              kv_q;
  logic [WORD_W-1:0] kw_q;
  logic [CNT_W-1:0]  ki_q;

  logic [PTR_W-1:0]  row_inc;
  logic [CNT_W-1:0]  rem_nx;
  logic              stop_nx;
  logic              bad_cfg;

  assign launch_o = (state_q == ST_IDLE) && start_i;
  assign accept_o = (state_q == ST_READ) && rd_ack_i && row_good_i;
  assign bad_cfg  = (nwords_i == '0) || (start_row_i > end_row_i);
  assign row_inc  = row_q + 1'b1;
  assign rem_nx   = accept_o ? rem_q - 1'b1 : rem_q;
  assign stop_nx  = (rem_nx == '0) || (row_inc > {1'b0, end_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      end_q   <= '0;
      rem_q   <= '0;
      idx_q   <= '0;
      bad_q   <= 1'b0;
      kv_q    <= 1'b0;
      kw_q    <= '0;
      ki_q    <= '0;
    end else begin
      kv_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            row_q   <= {1'b0, start_row_i};
            end_q   <= end_row_i;
            rem_q   <= nwords_i;
            idx_q   <= '0;
            bad_q   <= bad_cfg;
            state_q <= bad_cfg ? ST_FIN : ST_READ;
          end
        end
        ST_READ: begin
          if (rd_ack_i) begin
            row_q <= row_inc;
            rem_q <= rem_nx;
            if (row_good_i) begin
              kv_q  <= 1'b1;
              kw_q  <= rd_data_i;
              ki_q  <= idx_q;
              idx_q <= idx_q + 1'b1;
            end
            if (stop_nx) state_q <= ST_FIN;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_o    = (state_q == ST_READ);
  assign rd_row_o    = row_q[ROW_W-1:0];
  assign key_valid_o = kv_q;
  assign key_word_o  = kw_q;
  assign key_idx_o   = ki_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_FIN);
  // pointer past end row fails even when the key completed on the end row
  assign pass_o      = done_o && !bad_q && acc_ok_i && (row_q <= {1'b0, end_q});
endmodule

// File: rtl/fuse_key_seq.sv
module fuse_key_seq #(
  parameter int ROW_W  = 10,
  parameter int WORD_W = 32,
  parameter int FAIL_W = 9,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ROW_W-1:0]  start_row_i,
  input  logic [ROW_W-1:0]  end_row_i,
  input  logic [CNT_W-1:0]  nwords_i,
  output logic              rd_req_o,
  output logic [ROW_W-1:0]  rd_row_o,
  input  logic              rd_ack_i,
  input  logic [WORD_W-1:0] rd_data_i,
  input  logic              rd_ecc_err_i,
  input  logic [FAIL_W-1:0] rd_fail_i,
  output logic              key_valid_o,
  output logic [WORD_W-1:0] key_word_o,
  output logic [CNT_W-1:0]  key_idx_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o
);
  logic row_good, launch, accept, acc_ok;

  fks_row_filter #(.FAIL_W(FAIL_W)) filt_i (
    .ecc_err_i (rd_ecc_err_i),
    .fail_i    (rd_fail_i),
    .good_o    (row_good)
  );

  fks_accum #(.WORD_W(WORD_W)) acc_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (launch),
    .upd_i  (accept),
    .word_i (rd_data_i),
    .ok_o   (acc_ok)
  );

  fks_ctrl #(.ROW_W(ROW_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) ctrl_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .start_row_i (start_row_i),
    .end_row_i   (end_row_i),
    .nwords_i    (nwords_i),
    .rd_ack_i    (rd_ack_i),
    .row_good_i  (row_good),
    .rd_data_i   (rd_data_i),
    .acc_ok_i    (acc_ok),
    .launch_o    (launch),
    .accept_o    (accept),
    .rd_req_o    (rd_req_o),
    .rd_row_o    (rd_row_o),
    .key_valid_o (key_valid_o),
    .key_word_o  (key_word_o),
    .key_idx_o   (key_idx_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .pass_o      (pass_o)
  );
endmodule

// File: rtl/fks_checker.sv
module fks_checker #(
  parameter int ROW_W  = 10,
  parameter int WORD_W = 32,
  parameter int FAIL_W = 9,
  parameter int CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ROW_W-1:0]  start_row_i,
  input logic [ROW_W-1:0]  end_row_i,
  input logic [CNT_W-1:0]  nwords_i,
  input logic              rd_req_o,
  input logic [ROW_W-1:0]  rd_row_o,
  input logic              rd_ack_i,
  input logic [WORD_W-1:0] rd_data_i,
  input logic              rd_ecc_err_i,
  input logic [FAIL_W-1:0] rd_fail_i,
  input logic              key_valid_o,
  input logic [WORD_W-1:0] key_word_o,
  input logic [CNT_W-1:0]  key_idx_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              pass_o
);
  logic [WORD_W-1:0] seen_or_q, seen_and_q, cur_or, cur_and;
  logic [ROW_W-1:0]  end_q, last_row_q;
  logic              take, bad_row;

  assign take    = start_i && !busy_o;
  assign bad_row = rd_ecc_err_i || (rd_fail_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_or_q  <= '0;
      seen_and_q <= '1;
      end_q      <= '0;
      last_row_q <= '0;
    end else begin
      if (take) begin
        seen_or_q  <= '0;
        seen_and_q <= '1;
        end_q      <= end_row_i;
      end else if (key_valid_o) begin
        seen_or_q  <= seen_or_q | key_word_o;
        seen_and_q <= seen_and_q & key_word_o;
      end
      if (rd_req_o && rd_ack_i) last_row_q <= rd_row_o;
    end
  end

  assign cur_or  = seen_or_q  | (key_valid_o ? key_word_o : '0);
  assign cur_and = seen_and_q & (key_valid_o ? key_word_o : '1);

  assert_row_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && rd_ack_i) |=> (!rd_req_o || rd_row_o == ROW_W'($past(rd_row_o) + 1'b1)));

  assert_row_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_row_o)));

  assert_skip_bad_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && rd_ack_i && bad_row) |=> !key_valid_o);

  assert_word_out_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && rd_ack_i && !bad_row) |=> (key_valid_o && key_word_o == $past(rd_data_i)));

  assert_not_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pass_o) |-> (cur_and != '1));

  assert_not_blank_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pass_o) |-> (cur_or != '0));

  assert_end_row_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pass_o) |-> (last_row_q < end_q));

  assert_bad_cfg_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && (nwords_i == '0 || start_row_i > end_row_i)) |=> (done_o && !pass_o && !rd_req_o));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  assert_pass_qual_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> done_o);
endmodule

bind fuse_key_seq fks_checker #(
  .ROW_W(ROW_W), .WORD_W(WORD_W), .FAIL_W(FAIL_W), .CNT_W(CNT_W)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .start_row_i  (start_row_i),
  .end_row_i    (end_row_i),
  .nwords_i     (nwords_i),
  .rd_req_o     (rd_req_o),
  .rd_row_o     (rd_row_o),
  .rd_ack_i     (rd_ack_i),
  .rd_data_i    (rd_data_i),
  .rd_ecc_err_i (rd_ecc_err_i),
  .rd_fail_i    (rd_fail_i),
  .key_valid_o  (key_valid_o),
  .key_word_o   (key_word_o),
  .key_idx_o    (key_idx_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .pass_o       (pass_o)
);

// File: tb/fuse_key_seq_tb.sv
module fuse_key_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W  = 4;
  localparam int WORD_W = 32;
  localparam int FAIL_W = 2;
  localparam int CNT_W  = 4;
  localparam int NROWS  = 1 << ROW_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [ROW_W-1:0]  start_row_i = '0;
  logic [ROW_W-1:0]  end_row_i = '0;
  logic [CNT_W-1:0]  nwords_i = '0;
  logic              rd_req_o;
  logic [ROW_W-1:0]  rd_row_o;
  logic              rd_ack_i = 1'b0;
  logic [WORD_W-1:0] rd_data_i = '0;
  logic              rd_ecc_err_i = 1'b0;
  logic [FAIL_W-1:0] rd_fail_i = '0;
  logic              key_valid_o;
  logic [WORD_W-1:0] key_word_o;
  logic [CNT_W-1:0]  key_idx_o;
  logic              busy_o, done_o, pass_o;

  fuse_key_seq #(.ROW_W(ROW_W), .WORD_W(WORD_W), .FAIL_W(FAIL_W), .CNT_W(CNT_W)) dut_i (
    .clk_i, .rst_ni, .start_i, .start_row_i, .end_row_i, .nwords_i,
    .rd_req_o, .rd_row_o, .rd_ack_i, .rd_data_i, .rd_ecc_err_i, .rd_fail_i,
    .key_valid_o, .key_word_o, .key_idx_o, .busy_o, .done_o, .pass_o
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  int total = 0;
  int failed = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // row contents per pattern
  function automatic logic [WORD_W-1:0] mdata(input int p, input int r);
    case (p)
      0:       return (32'h1000_0001 * (r + 1)) ^ (32'(r) << 8);
      1:       return '0;
      2:       return '1;
      default: return (r % 2 == 1) ? '1 : '0;
    endcase
  endfunction

  function automatic logic mecc(input int p, input int r);
    return (p == 0 || p == 3) && (r % 5 == 3);
  endfunction

  function automatic logic [FAIL_W-1:0] mfail(input int p, input int r);
    if (p == 0 && r % 7 == 2) return 2'b10;
    if (p == 3 && r % 6 == 1) return 2'b01;
    return 2'b00;
  endfunction

  // responder and monitor
  int cur_p = 0, lat = 0, wait_cnt = 0;
  int got_n = 0, got_nreq = 0, done_cnt = 0;
  logic [WORD_W-1:0] got_w [16];
  int got_idx [16];
  int got_row [32];
  logic got_pass = 1'b0;

  always @(negedge clk_i) begin
    if (rd_req_o && wait_cnt >= lat) begin
      rd_ack_i     = 1'b1;
      rd_data_i    = mdata(cur_p, int'(rd_row_o));
      rd_ecc_err_i = mecc(cur_p, int'(rd_row_o));
      rd_fail_i    = mfail(cur_p, int'(rd_row_o));
      if (got_nreq < 32) got_row[got_nreq] = int'(rd_row_o);
      got_nreq++;
      wait_cnt = 0;
    end else begin
      rd_ack_i     = 1'b0;
      rd_data_i    = 32'h5a5a_a5a5;
      rd_ecc_err_i = 1'b0;
      rd_fail_i    = '0;
      if (rd_req_o) wait_cnt++;
    end
    if (key_valid_o) begin
      if (got_n < 16) begin
        got_w[got_n]   = key_word_o;
        got_idx[got_n] = int'(key_idx_o);
      end
      got_n++;
    end
    if (done_o) begin
      done_cnt++;
      got_pass = pass_o;
    end
  end

  task automatic run(input int p, input int s, input int e, input int n);
    logic [WORD_W-1:0] ew [16];
    int erow [32];
    int ne = 0, nr = 0, row = s, rem = n;
    logic [WORD_W-1:0] or_a = '0, and_a = '1;
    bit bad = (n == 0) || (s > e);
    bit exp_pass;
    string tag;
    if (!bad) begin
      while (rem > 0 && row <= e) begin
        erow[nr] = row; nr++;
        if (!mecc(p, row) && mfail(p, row) == '0) begin
          ew[ne] = mdata(p, row);
          or_a  |= ew[ne];
          and_a &= ew[ne];
          ne++; rem--;
        end
        row++;
      end
    end
    if (bad)                tag = "R8";
    else if (and_a == '1)   tag = "R5";
    else if (or_a == '0)    tag = "R6";
    else if (row > e)       tag = "R7";
    else                    tag = "R10";
    exp_pass = !bad && and_a != '1 && or_a != '0 && row <= e;

    cur_p = p; lat = (s ^ n) & 1; wait_cnt = 0;
    got_n = 0; got_nreq = 0; done_cnt = 0;
    @(negedge clk_i);
    start_i = 1'b1; start_row_i = ROW_W'(s); end_row_i = ROW_W'(e); nwords_i = CNT_W'(n);
    @(negedge clk_i);
    // held start with other parameters must be ignored (R9)
    start_row_i = '0; end_row_i = '1; nwords_i = '1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int t = 0; t < 200 && done_cnt == 0; t++) @(posedge clk_i);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);

    chk(done_cnt == 1, "R9", "done pulse count", done_cnt, 1);
    chk(!busy_o, "R9", "busy after done", busy_o, 0);
    chk(got_pass == exp_pass, tag, "verdict", got_pass, exp_pass);
    chk(got_nreq == nr, bad ? "R8" : "R4", "rows read", got_nreq, nr);
    for (int i = 0; i < nr && i < got_nreq; i++)
      chk(got_row[i] == erow[i], "R1", "row order", got_row[i], erow[i]);
    chk(got_n == ne, "R2", "key word count", got_n, ne);
    for (int i = 0; i < ne && i < got_n; i++) begin
      chk(got_w[i] == ew[i], "R3", "key word", got_w[i], ew[i]);
      chk(got_idx[i] == i, "R3", "key index", got_idx[i], i);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    total++; failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(!busy_o && !done_o && !pass_o, "R9", "reset status", {busy_o, done_o, pass_o}, 0);
    chk(!rd_req_o && !key_valid_o, "R9", "reset port", {rd_req_o, key_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !rd_req_o, "R9", "idle after reset", {busy_o, rd_req_o}, 0);
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < NROWS; s++)
        for (int e = 0; e < NROWS; e++)
          for (int n = 0; n < 5; n++)
            run(p, s, e, n);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule